// File: doc/BRIEF.md
# Flash Lane-Configurable Read Sequencer

This block fetches one byte at a time from a serial NOR flash device. Software sets up an opcode source, a three- or four-byte address and a lane mode through a small byte-wide register port, then sets a start bit. The sequencer selects the flash, clocks out the opcode on a single line, clocks out the address on one, two or four lines, waits a number of dummy clocks that depends only on the lane combination, and then shifts in eight data bits on one, two or four lines. The byte lands in a read-back register and the start bit drops in the same cycle.

The pin side is a four-line serial interface with separate output, output-enable and input vectors, so a pad ring can build bidirectional lines from it. The serial clock idles low, data leaves on the falling edge and is sampled on the rising edge. Its half period is a parameter counted in system clocks. The configuration is captured when a read launches, so software may prepare the next read while one is running.

Top module: `flash_read_seq`

## Requirements
- R1: After reset the chip select is high, the serial clock is low, all output enables are off, and the control, mode and read-back registers read 0.
- R2: Register offsets: 0x0 control (bit 0 start), 0x1 lane mode, 0x2 option (bit 0 fast read), 0x3 dual opcode, 0x4 quad opcode, 0x8 to 0xB address bytes from least to most significant, 0xC received byte. Unmapped offsets read 0. The mode register keeps five bits: bit 0 dual data, bit 1 dual address, bit 2 quad data, bit 3 quad address, bit 4 four-byte address. Quad data takes precedence over dual data. An address-lane bit only applies together with the matching data bit.
- R3: The opcode goes out on line 0 only, MSB first, over 8 clocks. It is the quad opcode in quad data mode and the dual opcode in dual data mode. In single mode it is 0x0B when the fast bit is set and 0x03 when it is clear.
- R4: The address goes out MSB first. It has 24 bits, or 32 bits with the four-byte bit set, in which case byte 0xB is the most significant byte. Two lanes use lines 1:0 with line 1 carrying the higher bit. Four lanes use lines 3:0 with line 3 carrying the highest bit of each nibble. Only the address lines are enabled.
- R5: The dummy clock count is 0 for single mode with fast clear and 8 for single mode with fast set. With dual or quad data it is 8 for a single-lane address, 4 for a dual-lane address and 6 for a quad-lane address. A read has 8, plus the address clocks, plus the dummy clocks, plus 8/lanes data clocks in total.
- R6: Data is sampled MSB first on line 1 in single mode, on lines 1:0 in dual mode and on lines 3:0 in quad mode. The resulting byte is readable at 0xC.
- R7: All output enables are off from the first dummy clock (or the first data clock when there is no dummy) until chip select returns high.
- R8: The start bit reads 1 while a read is in flight and clears in the same cycle the received byte becomes readable.
- R9: Register writes made during a read, including a second start, leave that read unchanged, and no read is launched by them.
- R10: The serial clock is low whenever chip select is high, and its period is 2*SCK_HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash select, active low |
| spi_io_o | output | 4 | Serial output values, lines 3:0 |
| spi_io_oe | output | 4 | Output enables, lines 3:0 |
| spi_io_i | input | 4 | Serial input values, lines 3:0 |

## Verification
The bench uses a flash model that records every rising serial clock edge. It goes after the lane decode corners: both data bits set at once (a design without quad precedence would run a dual read), address-lane bits without their data bit (a naive decode would widen the address), and single mode with and without fast read (a wrong dummy count shifts every data bit). Noise on the unused input lines exposes sampling on the wrong line. Writes made in the middle of a read expose a design that reads live registers instead of a snapshot, or one that relaunches on a second start.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int unsigned RA_W    = 4;
  localparam int unsigned OP_W    = 8;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned TX_W    = OP_W + ADDR_W;
  localparam int unsigned CLK_W   = 6;
  localparam int unsigned ABYTES  = ADDR_W / 8;

  localparam logic [RA_W-1:0] RA_CTRL  = 4'h0;
  localparam logic [RA_W-1:0] RA_MODE  = 4'h1;
  localparam logic [RA_W-1:0] RA_OPT   = 4'h2;
  localparam logic [RA_W-1:0] RA_OPD   = 4'h3;
  localparam logic [RA_W-1:0] RA_OPQ   = 4'h4;
  localparam logic [RA_W-1:0] RA_ADR0  = 4'h8;
  localparam logic [RA_W-1:0] RA_RDATA = 4'hC;

  localparam logic [OP_W-1:0] OP_SLOW = 8'h03;
  localparam logic [OP_W-1:0] OP_FAST = 8'h0B;

  typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lane_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_FINISH
  } seq_e;

  typedef struct packed {
    lane_e           a_lane;
    lane_e           d_lane;
    logic [3:0]      dummy;
    logic [OP_W-1:0] opcode;
    logic            wide_addr;
  } plan_t;

  function automatic logic [2:0] lane_bits(lane_e l);
    case (l)
      LN_1:    return 3'd1;
      LN_2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/frs_lane_plan.sv
module frs_lane_plan
  import frs_pkg::*;
(
  input  logic [4:0]      mode,
  input  logic            fast,
  input  logic [OP_W-1:0] op_dual,
  input  logic [OP_W-1:0] op_quad,
  output plan_t           plan
);
  always_comb begin
    plan           = '0;
    plan.wide_addr = mode[4];
    if (mode[2]) begin
      plan.d_lane = LN_4;
      plan.a_lane = mode[3] ? LN_4 : LN_1;
      plan.opcode = op_quad;
    end else if (mode[0]) begin
      plan.d_lane = LN_2;
      plan.a_lane = mode[1] ? LN_2 : LN_1;
      plan.opcode = op_dual;
    end else begin
      plan.d_lane = LN_1;
      plan.a_lane = LN_1;
      plan.opcode = fast ? OP_FAST : OP_SLOW;
    end
    if (plan.d_lane == LN_1) begin
      plan.dummy = fast ? 4'd8 : 4'd0;
    end else begin
      case (plan.a_lane)
        LN_1:    plan.dummy = 4'd8;
        LN_2:    plan.dummy = 4'd4;
        default: plan.dummy = 4'd6;
      endcase
    end
  end
endmodule

// File: rtl/frs_sck_gen.sv
module frs_sck_gen #(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int unsigned CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          tick;

  always_comb begin
    tick     = run && (cnt_q == CW'(SCK_HALF - 1));
    rise_evt = tick && !sck_q;
    fall_evt = tick && sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = !sck_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
      sck_d = sck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck = sck_q;

  p_rise_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> sck_q);
  p_fall_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !sck_q);
endmodule

// File: rtl/frs_regs.sv
module frs_regs
  import frs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [RA_W-1:0]   addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              done,
  input  logic [7:0]        rx_byte,
  output logic [4:0]        mode,
  output logic              fast,
  output logic [OP_W-1:0]   op_dual,
  output logic [OP_W-1:0]   op_quad,
  output logic [ADDR_W-1:0] addr_word,
  output logic              start
);
  logic            start_q;
  logic [4:0]      mode_q;
  logic            fast_q;
  logic [OP_W-1:0] opd_q, opq_q;
  logic [7:0]      rdata_q;
  logic [7:0]      adr_q [ABYTES];

  logic we_ctrl, we_mode, we_opt, we_opd, we_opq;
  assign we_ctrl = wen && (addr == RA_CTRL);
  assign we_mode = wen && (addr == RA_MODE);
  assign we_opt  = wen && (addr == RA_OPT);
  assign we_opd  = wen && (addr == RA_OPD);
  assign we_opq  = wen && (addr == RA_OPQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
    end else if (done) begin
      start_q <= 1'b0;
    end else if (we_ctrl && !start_q) begin
      start_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      fast_q  <= 1'b0;
      opd_q   <= '0;
      opq_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (we_mode) mode_q  <= wdata[4:0];
      if (we_opt)  fast_q  <= wdata[0];
      if (we_opd)  opd_q   <= wdata;
      if (we_opq)  opq_q   <= wdata;
      if (done)    rdata_q <= rx_byte;
    end
  end

  for (genvar b = 0; b < ABYTES; b++) begin : g_adr
    logic we_b;
    assign we_b = wen && (addr == RA_ADR0 + RA_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        adr_q[b] <= '0;
      end else if (we_b) begin
        adr_q[b] <= wdata;
      end
    end
    assign addr_word[8*b +: 8] = adr_q[b];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL:  rdata = {7'd0, start_q};
      RA_MODE:  rdata = {3'd0, mode_q};
      RA_OPT:   rdata = {7'd0, fast_q};
      RA_OPD:   rdata = opd_q;
      RA_OPQ:   rdata = opq_q;
      RA_RDATA: rdata = rdata_q;
      default: begin
        for (int b = 0; b < ABYTES; b++) begin
          if (addr == RA_ADR0 + RA_W'(b)) rdata = adr_q[b];
        end
      end
    endcase
  end

  assign mode    = mode_q;
  assign fast    = fast_q;
  assign op_dual = opd_q;
  assign op_quad = opq_q;
  assign start   = start_q;

  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !start_q);
  p_rdata_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> $past(done));
endmodule

// File: rtl/frs_sequencer.sv
module frs_sequencer
  import frs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  plan_t             plan_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic [3:0]        io_i,
  output logic              run,
  output logic              cs_n,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe,
  output logic              done,
  output logic [7:0]        rx_byte
);
  seq_e             state_q, state_d;
  logic [CLK_W-1:0] left_q, left_d;
  logic [TX_W-1:0]  tx_q, tx_d;
  logic [7:0]       rx_q, rx_d;
  plan_t            plan_q, plan_d;

  logic [CLK_W-1:0] addr_clks, data_clks;
  logic             last;

  assign addr_clks = (plan_q.wide_addr ? CLK_W'(32) : CLK_W'(24)) >> plan_q.a_lane;
  assign data_clks = CLK_W'(8) >> plan_q.d_lane;
  assign last      = (left_q == CLK_W'(1));

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    plan_d  = plan_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_CMD;
          left_d  = CLK_W'(8);
          plan_d  = plan_in;
          rx_d    = '0;
          tx_d    = plan_in.wide_addr ? {plan_in.opcode, addr_in}
                                      : {plan_in.opcode, addr_in[23:0], 8'h00};
        end
      end
      ST_CMD: begin
        if (fall_evt) begin
          tx_d = tx_q << 1;
          if (last) begin
            state_d = ST_ADDR;
            left_d  = addr_clks;
          end else begin
            left_d = left_q - CLK_W'(1);
          end
        end
      end
      ST_ADDR: begin
        if (fall_evt) begin
          tx_d = tx_q << lane_bits(plan_q.a_lane);
          if (last) begin
            if (plan_q.dummy != 4'd0) begin
              state_d = ST_DUMMY;
              left_d  = CLK_W'(plan_q.dummy);
            end else begin
              state_d = ST_DATA;
              left_d  = data_clks;
            end
          end else begin
            left_d = left_q - CLK_W'(1);
          end
        end
      end
      ST_DUMMY: begin
        if (fall_evt) begin
          if (last) begin
            state_d = ST_DATA;
            left_d  = data_clks;
          end else begin
            left_d = left_q - CLK_W'(1);
          end
        end
      end
      ST_DATA: begin
        if (rise_evt) begin
          case (plan_q.d_lane)
            LN_1:    rx_d = {rx_q[6:0], io_i[1]};
            LN_2:    rx_d = {rx_q[5:0], io_i[1:0]};
            default: rx_d = {rx_q[3:0], io_i};
          endcase
        end
        if (fall_evt) begin
          if (last) state_d = ST_FINISH;
          else      left_d  = left_q - CLK_W'(1);
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      plan_q  <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      plan_q  <= plan_d;
    end
  end

  always_comb begin
    io_o  = '0;
    io_oe = '0;
    case (state_q)
      ST_CMD: begin
        io_o[0] = tx_q[TX_W-1];
        io_oe   = 4'b0001;
      end
      ST_ADDR: begin
        case (plan_q.a_lane)
          LN_1: begin
            io_o[0] = tx_q[TX_W-1];
            io_oe   = 4'b0001;
          end
          LN_2: begin
            io_o[1:0] = tx_q[TX_W-1 -: 2];
            io_oe     = 4'b0011;
          end
          default: begin
            io_o  = tx_q[TX_W-1 -: 4];
            io_oe = 4'b1111;
          end
        endcase
      end
      default: ;
    endcase
  end

  assign run     = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                   (state_q == ST_DUMMY) || (state_q == ST_DATA);
  assign cs_n    = !run;
  assign done    = (state_q == ST_FINISH);
  assign rx_byte = rx_q;

  p_launch_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start) |=> (!cs_n && io_oe == 4'b0001));
endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
  import frs_pkg::*;
#(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wen,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic [3:0] spi_io_o,
  output logic [3:0] spi_io_oe,
  input  logic [3:0] spi_io_i
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [4:0]        mode;
  logic              fast, start, done, run, rise_evt, fall_evt;
  logic [OP_W-1:0]   op_dual, op_quad;
  logic [ADDR_W-1:0] addr_word;
  logic [7:0]        rx_byte;
  plan_t             plan;

  frs_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .done(done), .rx_byte(rx_byte),
    .mode(mode), .fast(fast), .op_dual(op_dual), .op_quad(op_quad),
    .addr_word(addr_word), .start(start)
  );

  frs_lane_plan u_plan (
    .mode(mode), .fast(fast), .op_dual(op_dual), .op_quad(op_quad), .plan(plan)
  );

  frs_sck_gen #(.SCK_HALF(SCK_HALF)) u_sck (
    .clk(clk), .rst_n(rst_int_n), .run(run), .sck(spi_sck),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  frs_sequencer u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .plan_in(plan),
    .addr_in(addr_word), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .io_i(spi_io_i), .run(run), .cs_n(spi_cs_n), .io_o(spi_io_o),
    .io_oe(spi_io_oe), .done(done), .rx_byte(rx_byte)
  );

  p_idle_sck_low_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    spi_cs_n |-> !spi_sck);
endmodule

// File: tb/test_flash_read_seq.sv
`timescale 1ns/1ps
module test_flash_read_seq;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wen = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_sck, spi_cs_n;
  logic [3:0] spi_io_o, spi_io_oe;
  logic [3:0] spi_io_i = 4'h0;

  flash_read_seq #(.SCK_HALF(HALF)) i_flash_read_seq (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe),
    .spi_io_i(spi_io_i)
  );

  always #2 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0, sck_bad = 0;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n && spi_cs_n && spi_sck) sck_bad++;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model
  int k = 0, fl_start = 0, fl_dl = 1, t0 = 0, t1 = 0;
  logic [7:0] fl_byte = 8'h00;
  logic [3:0] cap_o [64];
  logic [3:0] cap_oe[64];

  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (k < 64) begin cap_o[k] = spi_io_o; cap_oe[k] = spi_io_oe; end
    if (k == 0) t0 = cyc;
    if (k == 1) t1 = cyc;
    k++;
  end

  always @(negedge spi_sck) begin
    logic [3:0] noise;
    int j;
    noise = 4'($urandom);
    j = k - fl_start;
    if (k >= fl_start && j < 8 / fl_dl) begin
      case (fl_dl)
        1:       spi_io_i = {noise[3:2], fl_byte[7-j], noise[0]};
        2:       spi_io_i = {noise[3:2], fl_byte[7-2*j -: 2]};
        default: spi_io_i = fl_byte[7-4*j -: 4];
      endcase
    end else begin
      spi_io_i = noise;
    end
  end

  // expected-value functions
  function automatic int f_dlanes(logic [4:0] m);
    if (m[2]) return 4;
    if (m[0]) return 2;
    return 1;
  endfunction
  function automatic int f_alanes(logic [4:0] m);
    if (m[2]) return m[3] ? 4 : 1;
    if (m[0]) return m[1] ? 2 : 1;
    return 1;
  endfunction
  function automatic int f_dummy(logic [4:0] m, logic fast);
    int al;
    if (f_dlanes(m) == 1) return fast ? 8 : 0;
    al = f_alanes(m);
    return (al == 1) ? 8 : (al == 2) ? 4 : 6;
  endfunction
  function automatic logic [7:0] f_op(logic [4:0] m, logic fast, logic [7:0] opd, logic [7:0] opq);
    if (m[2]) return opq;
    if (m[0]) return opd;
    return fast ? 8'h0B : 8'h03;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 1'b0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic do_read(input logic [4:0] m, input logic fast, input logic [7:0] opd,
                         input logic [7:0] opq, input logic [31:0] a,
                         input logic [7:0] dbyte, input bit disturb);
    int al, dl, dm, acl, total, tmo, lows;
    logic [7:0] v, op;
    logic [31:0] acc, aexp;
    logic [3:0] oe_exp;
    bit ok;
    wr(4'h1, {3'b000, m}); wr(4'h2, {7'd0, fast}); wr(4'h3, opd); wr(4'h4, opq);
    for (int b = 0; b < 4; b++) wr(4'h8 + 4'(b), a[8*b +: 8]);
    al = f_alanes(m); dl = f_dlanes(m); dm = f_dummy(m, fast); op = f_op(m, fast, opd, opq);
    acl = (m[4] ? 32 : 24) / al;
    fl_start = 8 + acl + dm; fl_dl = dl; fl_byte = dbyte; total = fl_start + 8 / dl;
    k = 0;
    wr(4'h0, 8'h01);
    rd(4'h0, v); chk("R8 start reads 1 while busy", longint'(v[0]), 1);
    if (disturb) begin
      repeat (20) @(negedge clk);
      wr(4'h1, ~{3'b000, m}); wr(4'h8, ~a[7:0]); wr(4'h4, ~opq); wr(4'h3, ~opd);
      wr(4'h2, {7'd0, ~fast}); wr(4'h0, 8'h01);
    end
    tmo = 0;
    do begin rd(4'h0, v); tmo++; end while (v[0] && tmo < 5000);
    rd(4'hC, v); chk("R6 received byte", v, dbyte);
    chk("R2 R5 total clock count", k, total);
    acc = '0; ok = 1'b1;
    for (int c = 0; c < 8; c++) begin
      acc = {acc[30:0], cap_o[c][0]};
      if (cap_oe[c] !== 4'b0001) ok = 1'b0;
    end
    chk("R3 opcode bits", acc[7:0], op);
    chk("R3 opcode line enables", ok, 1);
    acc = '0; ok = 1'b1;
    oe_exp = (al == 1) ? 4'b0001 : (al == 2) ? 4'b0011 : 4'b1111;
    for (int c = 8; c < 8 + acl && c < 64; c++) begin
      case (al)
        1:       acc = {acc[30:0], cap_o[c][0]};
        2:       acc = {acc[29:0], cap_o[c][1:0]};
        default: acc = {acc[27:0], cap_o[c]};
      endcase
      if (cap_oe[c] !== oe_exp) ok = 1'b0;
    end
    aexp = m[4] ? a : {8'h00, a[23:0]};
    chk("R4 address bits", acc, aexp);
    chk("R4 address line enables", ok, 1);
    ok = 1'b1;
    for (int c = 8 + acl; c < k && c < 64; c++) if (cap_oe[c] !== 4'b0000) ok = 1'b0;
    chk("R7 lines released after address", ok, 1);
    chk("R10 sck period", t1 - t0, 2 * HALF);
    if (disturb) begin
      lows = 0;
      repeat (40) begin @(negedge clk); if (!spi_cs_n) lows++; end
      chk("R9 no relaunch from write during read", lows, 0);
    end
  endtask

  initial begin
    #(4 * 190000);
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_0c1a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n after reset", spi_cs_n, 1);
    chk("R1 sck after reset", spi_sck, 0);
    chk("R1 oe after reset", spi_io_oe, 0);
    rd(4'h0, v); chk("R1 control after reset", v, 0);
    rd(4'h1, v); chk("R1 mode after reset", v, 0);
    rd(4'hC, v); chk("R1 read-back after reset", v, 0);
    // R2 register masking and unmapped offsets
    wr(4'h1, 8'hFF); rd(4'h1, v); chk("R2 mode keeps five bits", v, 8'h1F);
    wr(4'h6, 8'hA5); rd(4'h6, v); chk("R2 unmapped offset reads 0", v, 0);
    // directed lane corners
    do_read(5'h00, 1'b0, 8'h3B, 8'h6B, 32'h12AB_CDEF, 8'hA5, 0); // R5 slow, no dummy
    do_read(5'h00, 1'b1, 8'h3B, 8'h6B, 32'h0000_0010, 8'h5A, 0); // R5 fast
    do_read(5'h01, 1'b0, 8'h3B, 8'h6B, 32'h00C3_3C81, 8'hC3, 0); // dual data
    do_read(5'h03, 1'b0, 8'hBB, 8'h6B, 32'h0055_AA11, 8'h96, 0); // dual/dual
    do_read(5'h04, 1'b0, 8'h3B, 8'h6B, 32'h0012_3456, 8'h1E, 0); // quad data
    do_read(5'h0C, 1'b1, 8'h3B, 8'hEB, 32'h00FE_DCBA, 8'hE7, 0); // quad/quad
    do_read(5'h1C, 1'b0, 8'h3B, 8'hEC, 32'h89AB_CDEF, 8'h81, 0); // 4-byte quad
    do_read(5'h05, 1'b0, 8'h3B, 8'h6B, 32'h0001_0203, 8'h7F, 0); // R2 quad precedence
    do_read(5'h0A, 1'b0, 8'h3B, 8'h6B, 32'h00A0_B0C0, 8'hFE, 0); // R2 addr bits alone
    do_read(5'h13, 1'b1, 8'hBC, 8'h6B, 32'hF00D_BEEF, 8'h3C, 0); // 4-byte dual
    do_read(5'h03, 1'b0, 8'hBB, 8'hEB, 32'h0033_4455, 8'h69, 1); // R9 disturbed
    for (int n = 0; n < 30; n++) begin
      do_read(5'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
              $urandom, 8'($urandom), 0);
    end
    chk("R10 sck low while deselected", sck_bad, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule